// File: doc/BRIEF.md
# Scan Digit Address Mapper with Scroll Offset

This block sits between the scan sequencer and the two display memories of a dot-matrix character display controller. For the digit position currently being scanned it produces two read addresses. One goes to the 64-entry character-code buffer. The other goes to the 16-entry symbol buffer.

The character path carries a 6-bit scroll offset. A one-cycle step strobe moves the offset one place left or right. A one-cycle home strobe clears it. Repeated steps scroll the segment part of the display through the whole character buffer. The symbol path ignores the offset and always maps a digit to its own fixed entry.

Both addresses are combinational in the digit select and the offset register. A strobe sampled at a clock edge is visible on the character address as soon as that edge has passed. The block holds no memory contents and does not parse commands.

Top module: `digit_addr_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge the offset becomes 0. Afterwards `digit_sel` value k (0..15, selecting digit k+1) gives `char_addr` = k, so digits 1..16 read 00h..0Fh.
- R2: `sym_addr` always equals `digit_sel`, whatever steps or homes have occurred.
- R3: A step with `step_dir` = 0 (left) decrements the offset by one. From the unshifted state, digit 1 then reads 3Fh and digit 16 reads 0Eh.
- R4: A step with `step_dir` = 1 (right) increments the offset by one. From the unshifted state, digit 1 then reads 01h and digit 16 reads 10h.
- R5: Each cycle with `step_en` high moves the offset by exactly one position. The new mapping is visible right after that clock edge, and steps accumulate.
- R6: `char_addr` = (offset + `digit_sel`) mod 64. The offset wraps modulo 64, so 64 steps in one direction restore the starting mapping.
- R7: A cycle with `home` high restores the unshifted mapping (offset 0) after the edge.
- R8: When `home` and `step_en` are both high in the same cycle, `home` wins and the offset becomes 0.
- R9: In a cycle with neither `step_en` nor `home` high, the offset and hence the mapping are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| digit_sel | input | 4 | Scanned digit, zero-based (value k = digit k+1) |
| step_en | input | 1 | One-cycle scroll step strobe |
| step_dir | input | 1 | Step direction: 0 left, 1 right |
| home | input | 1 | One-cycle strobe that clears the scroll offset |
| char_addr | output | 6 | Character-code buffer read address |
| sym_addr | output | 4 | Symbol buffer read address |

## Verification
The hardest situation to reach is the wrap of the offset across the 00h/3Fh boundary, combined with accumulated history. It only shows up after many strobes in a particular direction. The stimulus therefore takes long single-direction runs of 64 steps, which must land back on the starting mapping. It also takes a long pseudo-random walk of left, right, idle and home cycles that crosses the boundary both ways. After every cycle all 16 digit selections are swept against an arithmetic model of the offset.

// File: rtl/digit_addr_pkg.sv
// Shared sizes and the step-direction encoding for the digit address mapper.
package digit_addr_pkg;
    localparam int NUM_DIGITS = 16;   // digits scanned on the display
    localparam int BUF_DEPTH  = 64;   // entries in the character-code buffer
    localparam int DIG_W      = $clog2(NUM_DIGITS);
    localparam int ADDR_W     = $clog2(BUF_DEPTH);

    typedef enum logic {
        STEP_LEFT  = 1'b0,
        STEP_RIGHT = 1'b1
    } step_dir_e;
endpackage

// File: rtl/scroll_offset_reg.sv
// Holds the scroll offset of the character path.
// Assumes step and home are one-cycle strobes; home has priority over step.
// The offset wraps naturally at 2**ADDR_W.
module scroll_offset_reg
    import digit_addr_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  step_dir_e           step_dir,
    input  logic                home,
    output logic [ADDR_W_P-1:0] offset
);
    localparam logic [ADDR_W_P-1:0] ONE = ADDR_W_P'(1);

    // Update the offset: clear on reset or home, otherwise step by one.
    always_ff @(posedge clk) begin
        if (!rst_n || home) begin
            offset <= '0;
        end else if (step_en) begin
            if (step_dir == STEP_RIGHT) offset <= offset + ONE;
            else                        offset <= offset - ONE;
        end
    end

    // R5
    right_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !home && step_dir == STEP_RIGHT) |=> offset == $past(offset) + ONE);
    // R5
    left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !home && step_dir == STEP_LEFT) |=> offset == $past(offset) - ONE);
    // R8
    home_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        home |=> offset == '0);
endmodule

// File: rtl/char_addr_gen.sv
// Forms the character-buffer address as offset plus digit index, modulo the buffer size.
// Assumes the digit index is no wider than the address.
module char_addr_gen #(
    parameter int ADDR_W_P = 6,
    parameter int DIG_W_P  = 4
) (
    input  logic [ADDR_W_P-1:0] offset,
    input  logic [DIG_W_P-1:0]  digit_sel,
    output logic [ADDR_W_P-1:0] char_addr
);
    logic [ADDR_W_P-1:0] digit_ext;

    // Widen the digit index to address width when narrower.
    generate
        if (DIG_W_P < ADDR_W_P) begin : g_pad
            assign digit_ext = {{(ADDR_W_P-DIG_W_P){1'b0}}, digit_sel};
        end else begin : g_same
            assign digit_ext = digit_sel[ADDR_W_P-1:0];
        end
    endgenerate

    // Modulo sum: the carry out of the top bit is dropped.
    always_comb begin
        char_addr = offset + digit_ext;
    end
endmodule

// File: rtl/sym_addr_gen.sv
// Maps a digit index straight to its symbol-buffer entry; never scrolled.
// Assumes one symbol entry per digit.
module sym_addr_gen #(
    parameter int DIG_W_P = 4
) (
    input  logic [DIG_W_P-1:0] digit_sel,
    output logic [DIG_W_P-1:0] sym_addr
);
    // Fixed identity mapping.
    always_comb begin
        sym_addr = digit_sel;
    end
endmodule

// File: rtl/digit_addr_mapper.sv
// Top: produces the character and symbol read addresses for the scanned digit.
// The character path is rotated by a scroll offset; the symbol path is fixed.
module digit_addr_mapper
    import digit_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIG_W-1:0]  digit_sel,
    input  logic              step_en,
    input  logic              step_dir,
    input  logic              home,
    output logic [ADDR_W-1:0] char_addr,
    output logic [DIG_W-1:0]  sym_addr
);
    logic [ADDR_W-1:0] offset;
    step_dir_e         dir_q;

    // Interpret the raw direction bit.
    always_comb begin
        dir_q = step_dir_e'(step_dir);
    end

    scroll_offset_reg #(.ADDR_W_P(ADDR_W)) off_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .step_dir (dir_q),
        .home     (home),
        .offset   (offset)
    );

    char_addr_gen #(.ADDR_W_P(ADDR_W), .DIG_W_P(DIG_W)) chr_i (
        .offset    (offset),
        .digit_sel (digit_sel),
        .char_addr (char_addr)
    );

    sym_addr_gen #(.DIG_W_P(DIG_W)) sym_i (
        .digit_sel (digit_sel),
        .sym_addr  (sym_addr)
    );

    // R2
    sym_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_addr == digit_sel);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !home && $stable(digit_sel)) |=> $stable(char_addr));
    // R7
    home_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (home && $stable(digit_sel)) |=> char_addr == ADDR_W'(digit_sel));
    // R6
    zero_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_sel == '0) |-> char_addr == offset);
endmodule

// File: tb/digit_addr_mapper_tb_top.sv
`timescale 1ns/100ps
module digit_addr_mapper_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit_sel = '0;
    logic       step_en = 1'b0;
    logic       step_dir = 1'b0;
    logic       home = 1'b0;
    logic [5:0] char_addr;
    logic [3:0] sym_addr;

    int tests = 0;
    int fails = 0;
    int model_off = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    digit_addr_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .digit_sel(digit_sel), .step_en(step_en),
        .step_dir(step_dir), .home(home), .char_addr(char_addr), .sym_addr(sym_addr)
    );

    // Sweep all digits after the edge; compare both addresses with the model.
    task automatic sweep(input string req);
        for (int d = 0; d < 16; d++) begin
            digit_sel = 4'(d);
            #0.1;
            tests++;
            if (char_addr != 6'((model_off + d) % 64)) begin
                fails++;
                $display("FAIL %s char digit=%0d actual=%0h expected=%0h",
                         req, d, char_addr, (model_off + d) % 64);
            end
            tests++;
            if (sym_addr != 4'(d)) begin
                fails++;
                $display("FAIL R2 sym digit=%0d actual=%0h expected=%0h", d, sym_addr, d);
            end
        end
    endtask

    // Drive one cycle of strobes at the falling edge, then sweep after the next rise.
    task automatic cycle(input logic s, input logic dir, input logic h, input string req);
        @(negedge clk);
        step_en = s; step_dir = dir; home = h;
        @(posedge clk);
        #1;
        step_en = 1'b0; home = 1'b0;
        if (h)      model_off = 0;
        else if (s) model_off = dir ? (model_off + 1) % 64 : (model_off + 63) % 64;
        sweep(req);
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_off = 0;
        sweep("R1");                       // R1 reset mapping
        cycle(1'b1, 1'b0, 1'b0, "R3");     // R3 left from initial: digit1=3F
        cycle(1'b1, 1'b0, 1'b1, "R7");     // R7 home (R8 home beats step)
        cycle(1'b1, 1'b1, 1'b0, "R4");     // R4 right from initial: digit16=10
        cycle(1'b1, 1'b1, 1'b0, "R5");     // R5 accumulates
        cycle(1'b0, 1'b0, 1'b0, "R9");     // R9 idle holds
        cycle(1'b1, 1'b1, 1'b1, "R8");     // R8 home wins over right step
        for (int i = 0; i < 64; i++) cycle(1'b1, 1'b0, 1'b0, "R6"); // R6 64 lefts
        tests++;
        if (model_off != 0) begin fails++; $display("FAIL R6 model wrap"); end
        for (int i = 0; i < 64; i++) cycle(1'b1, 1'b1, 1'b0, "R6"); // R6 64 rights
        // R5 R6 R9 pseudo-random walk
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cycle(lfsr[0] | lfsr[3], lfsr[1], (lfsr[7:2] == 6'h2A), "R5");
        end
        // R1 reset again after a shifted state
        cycle(1'b1, 1'b1, 1'b0, "R5");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1; model_off = 0;
        sweep("R1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule